// File: doc/BRIEF.md
# Mode-3 SPI Master with Phase-Sequenced Bit Timing

This block is a single-channel SPI master that moves 32-bit words to and from one slave device. The serial clock idles high, and both ends capture data on its rising edge. Every bit passes through two timed phases. In the low phase the master pulls the serial clock low and presents the next outgoing bit. In the high phase it raises the serial clock and captures the incoming bit at that same edge. A frame opens with a chip-select lead phase and closes with a chip-select tail phase. The length of every phase is set by a half-period parameter counted in system clocks. For example, a value of 5 gives roughly 5 MHz from a 50 MHz system clock.

Out of reset the master sends one frame carrying a fixed setup word, so that the slave starts from a known state. Only after that frame does it accept requests from the user side. A user requests a transfer with a one-cycle start pulse and a transmit word. The master reports progress through a busy level. It then pulses a done flag for one cycle, together with the received word.

Top module: `spi_mode3_master`

## Requirements
- R1: While reset is held, serialCsN is 1, serialClk is 1, done is 0 and busy is 1, because the setup frame is still pending.
- R2: On the first clock edge after reset is released, the master starts a frame carrying the INIT_WORD parameter without any user request. Start pulses are ignored until the done pulse of that frame.
- R3: serialClk is 1 whenever serialCsN is 1. Outside a frame the clock rests high.
- R4: serialMosi changes only at the edge that drives serialClk low. It carries the transmit word most significant bit first. Bit 31 is sent in the first low phase and bit 0 in the last.
- R5: The master captures serialMiso exactly once on each of the 32 rising serialClk edges of a frame, most significant bit first. With serialMiso looped back from serialMosi, rxWord equals the transmitted word exactly, with no shift by one position. rxWord changes only on a done cycle.
- R6: Once a start is accepted, serialCsN is 0 for HALF_DIV cycles before the first falling edge of serialClk. It stays 0 for 2*HALF_DIV cycles after the last rising edge. The whole frame lasts 66*HALF_DIV cycles.
- R7: After the chip-select tail phase the master returns to idle. A start given on the cycle in which busy is 0 begins a new frame, including one given right after a done pulse.
- R8: A start pulse that arrives while busy is 1 has no effect on the current frame and is not queued.
- R9: done is a single-cycle pulse. It coincides with serialCsN returning to 1, and with rxWord holding the word received in that frame.
- R10: Each clock phase, and each chip-select lead and tail phase, lasts HALF_DIV system clocks, with HALF_DIV at least 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle transfer request |
| txWord | input | 32 | Word to send, sampled when a start is accepted |
| rxWord | output | 32 | Last received word |
| busy | output | 1 | High while a frame runs or the setup frame is pending |
| done | output | 1 | One-cycle pulse at the end of a frame |
| serialClk | output | 1 | Serial clock, idles high |
| serialCsN | output | 1 | Active-low slave select |
| serialMosi | output | 1 | Serial data to the slave |
| serialMiso | input | 1 | Serial data from the slave |

## Verification
The hardest situations to reach from the ports are starts that coincide with busy phases. One is a start raised during the automatic setup frame, before the user has seen any done. Another is a start presented on the very cycle in which busy falls. The stimulus pulses start a few cycles after reset and again in the middle of a user frame, each time with a different transmit word. This makes any wrongly accepted request show up on serialMosi and in rxWord. The stimulus then chains frames by raising start on the same cycle in which done is observed. Looping serialMiso back from serialMosi, once inverted, exposes any off-by-one shift in capture, including for all-zero, all-one and alternating-bit words.

// File: rtl/spim_pkg.sv
package spim_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_CSLEAD, ST_LOW, ST_HIGH, ST_CSTAIL
  } spimState_t;

  typedef struct packed {
    logic load;     // capture the outgoing word
    logic useInit;  // load the setup word instead of txWord
    logic csOn;     // pull select low
    logic fall;     // drive serial clock low, present next bit
    logic rise;     // drive serial clock high, capture input bit
    logic finish;   // release select, publish received word
  } spimStrobe_t;
endpackage

// File: rtl/spim_ctrl.sv
module spim_ctrl
  import spim_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int HALF_DIV = 5
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  output spimStrobe_t strobe,
  output logic        busy
);
  localparam int CNT_W = $clog2(HALF_DIV + 1);
  localparam int BIT_W = $clog2(DATA_W + 1);

  spimState_t state, nextState;
  logic [CNT_W-1:0] halfCnt;
  logic [BIT_W-1:0] bitCnt;
  logic             initPending;
  logic             halfDone;

  assign halfDone = (halfCnt == CNT_W'(HALF_DIV - 1));

  always_comb begin
    nextState = state;
    strobe    = '0;
    case (state)
      ST_IDLE: begin
        if (initPending || start) begin
          strobe.load    = 1'b1;
          strobe.useInit = initPending;
          strobe.csOn    = 1'b1;
          nextState      = ST_CSLEAD;
        end
      end
      ST_CSLEAD: begin
        if (halfDone) begin
          strobe.fall = 1'b1;
          nextState   = ST_LOW;
        end
      end
      ST_LOW: begin
        if (halfDone) begin
          strobe.rise = 1'b1;
          nextState   = ST_HIGH;
        end
      end
      ST_HIGH: begin
        if (halfDone) begin
          if (bitCnt == BIT_W'(DATA_W)) begin
            nextState = ST_CSTAIL;
          end else begin
            strobe.fall = 1'b1;
            nextState   = ST_LOW;
          end
        end
      end
      ST_CSTAIL: begin
        if (halfDone) begin
          strobe.finish = 1'b1;
          nextState     = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      halfCnt     <= '0;
      bitCnt      <= '0;
      initPending <= 1'b1;
    end else begin
      state <= nextState;
      if (state == ST_IDLE || nextState != state) halfCnt <= '0;
      else                                        halfCnt <= halfCnt + 1'b1;
      if (strobe.load)      bitCnt <= '0;
      else if (strobe.rise) bitCnt <= bitCnt + 1'b1;
      if (strobe.load) initPending <= 1'b0;
    end
  end

  assign busy = (state != ST_IDLE) || initPending;
endmodule

// File: rtl/spim_datapath.sv
module spim_datapath
  import spim_pkg::*;
#(
  parameter int          DATA_W    = 32,
  parameter logic [31:0] INIT_WORD = 32'h0
) (
  input  logic              clk,
  input  logic              rstN,
  input  spimStrobe_t       strobe,
  input  logic [DATA_W-1:0] txWord,
  input  logic              serialMiso,
  output logic [DATA_W-1:0] rxWord,
  output logic              done,
  output logic              serialClk,
  output logic              serialCsN,
  output logic              serialMosi
);
  logic [DATA_W-1:0] txShift;
  logic [DATA_W-1:0] rxShift;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txShift    <= '0;
      rxShift    <= '0;
      rxWord     <= '0;
      done       <= 1'b0;
      serialClk  <= 1'b1;
      serialCsN  <= 1'b1;
      serialMosi <= 1'b0;
    end else begin
      done <= 1'b0;
      if (strobe.load) txShift <= strobe.useInit ? INIT_WORD[DATA_W-1:0] : txWord;
      if (strobe.csOn) serialCsN <= 1'b0;
      if (strobe.fall) begin
        serialClk  <= 1'b0;
        serialMosi <= txShift[DATA_W-1];
        txShift    <= {txShift[DATA_W-2:0], 1'b0};
      end
      if (strobe.rise) begin
        serialClk <= 1'b1;
        rxShift   <= {rxShift[DATA_W-2:0], serialMiso};
      end
      if (strobe.finish) begin
        serialCsN <= 1'b1;
        rxWord    <= rxShift;
        done      <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_mode3_master.sv
module spi_mode3_master
  import spim_pkg::*;
#(
  parameter int          DATA_W    = 32,
  parameter int          HALF_DIV  = 5,
  parameter logic [31:0] INIT_WORD = 32'h0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [DATA_W-1:0] txWord,
  output logic [DATA_W-1:0] rxWord,
  output logic              busy,
  output logic              done,
  output logic              serialClk,
  output logic              serialCsN,
  output logic              serialMosi,
  input  logic              serialMiso
);
  spimStrobe_t strobe;

  spim_ctrl #(.DATA_W(DATA_W), .HALF_DIV(HALF_DIV)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .strobe(strobe), .busy(busy)
  );

  spim_datapath #(.DATA_W(DATA_W), .INIT_WORD(INIT_WORD)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .txWord(txWord),
    .serialMiso(serialMiso), .rxWord(rxWord), .done(done),
    .serialClk(serialClk), .serialCsN(serialCsN), .serialMosi(serialMosi)
  );
endmodule

// File: rtl/spim_checker.sv
module spim_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              done,
  input logic              serialClk,
  input logic              serialCsN,
  input logic              serialMosi,
  input logic [DATA_W-1:0] rxWord
);
  localparam int RC_W = $clog2(DATA_W + 1) + 1;
  logic [RC_W-1:0] riseCnt;
  logic            prevClk;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      riseCnt <= '0;
      prevClk <= 1'b1;
    end else begin
      prevClk <= serialClk;
      if (serialCsN) riseCnt <= '0;
      else if (serialClk && !prevClk) riseCnt <= riseCnt + 1'b1;
    end
  end

  AST_CLK_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    serialCsN |-> serialClk); // R3
  AST_MOSI_ON_FALL: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(serialMosi) |-> !serialClk); // R4
  AST_RX_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rxWord) |-> done); // R5
  AST_RISE_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(serialCsN) |-> riseCnt == RC_W'(DATA_W)); // R5
  AST_CLK_FALL_IN_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    $fell(serialClk) |-> !serialCsN); // R6
  AST_SELECT_MEANS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    !serialCsN |-> busy); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R9
  AST_DONE_WITH_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $rose(serialCsN)); // R9
endmodule

bind spi_mode3_master spim_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .done(done), .serialClk(serialClk),
  .serialCsN(serialCsN), .serialMosi(serialMosi), .rxWord(rxWord)
);

// File: tb/spi_mode3_master_bench.sv
module spi_mode3_master_bench;
  localparam int          CLK_PERIOD = 10;
  localparam int          H          = 3;
  localparam int          W          = 32;
  localparam logic [31:0] INIT_W     = 32'hA5C3_0F01;
  localparam int          FRAME_LEN  = 66 * H;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [W-1:0]  txWord = '0;
  logic [W-1:0]  rxWord;
  logic          busy, done, serialClk, serialCsN, serialMosi, serialMiso;
  logic          invertLoop = 1'b0;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign serialMiso = serialMosi ^ invertLoop;

  spi_mode3_master #(.DATA_W(W), .HALF_DIV(H), .INIT_WORD(INIT_W)) u_spi_mode3_master (
    .clk(clk), .rstN(rstN), .start(start), .txWord(txWord), .rxWord(rxWord),
    .busy(busy), .done(done), .serialClk(serialClk), .serialCsN(serialCsN),
    .serialMosi(serialMosi), .serialMiso(serialMiso)
  );

  // behavioural reference, advanced on every clock
  bit           mActive, mPendInit, mDone;
  int           mT;
  logic [W-1:0] mWord, mRx;

  always @(posedge clk) begin
    if (!rstN) begin
      mActive = 0; mPendInit = 1; mDone = 0; mT = 0; mWord = '0; mRx = '0;
    end else begin
      mDone = 0;
      if (!mActive) begin
        if (mPendInit) begin
          mActive = 1; mT = 0; mWord = INIT_W; mPendInit = 0;
        end else if (start) begin
          mActive = 1; mT = 0; mWord = txWord;
        end
      end else begin
        mT++;
        if (mT == FRAME_LEN) begin
          mActive = 0; mDone = 1; mRx = mWord ^ {W{invertLoop}};
        end
      end
    end
  end

  function automatic bit expClk();
    if (!mActive || mT < H || mT >= 65 * H) return 1'b1;
    return (((mT - H) / H) % 2) == 1;
  endfunction

  function automatic bit expMosi();
    int k = (mT - H) / (2 * H);
    if (k > W - 1) k = W - 1;
    return mWord[W-1-k];
  endfunction

  task automatic check(input bit ok, input string tag, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    if (!rstN) begin
      check(serialCsN == 1 && serialClk == 1 && done == 0 && busy == 1,
            "R1 reset state", {serialCsN, serialClk, done, busy}, 4'b1101);
    end else begin
      check(serialClk == expClk(), "R3/R10 serialClk", serialClk, expClk());
      check(serialCsN == !mActive, "R6 serialCsN window", serialCsN, !mActive);
      check(busy == (mActive || mPendInit), "R7/R8 busy", busy, mActive || mPendInit);
      check(done == mDone, "R9 done pulse", done, mDone);
      check(rxWord == mRx, "R5 rxWord", rxWord, mRx);
      if (mActive && mT >= H)
        check(serialMosi == expMosi(), "R4 serialMosi bit", serialMosi, expMosi());
    end
  end

  task automatic finishRun();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=%0d expected<=100000", cycles);
      finishRun();
    end
  end

  task automatic waitDone();
    int n = 0;
    while (!done && n < 3 * FRAME_LEN) begin @(negedge clk); n++; end
  endtask

  // start presented at once, on the current negedge
  task automatic launch(input logic [W-1:0] w);
    txWord = w; start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic frame(input logic [W-1:0] w, input string tag);
    int n = 0;
    while (busy && n < 3 * FRAME_LEN) begin @(negedge clk); n++; end
    launch(w);
    waitDone();
    check(done && rxWord == (w ^ {W{invertLoop}}), tag, rxWord, w ^ {W{invertLoop}});
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    // R2: a start during the setup frame must be dropped
    repeat (5) @(negedge clk);
    launch(32'hDEAD_BEEF);
    waitDone();
    check(done && rxWord == INIT_W, "R2 setup frame word", rxWord, INIT_W);
    // R7: start on the same cycle busy drops after done
    launch(32'h0000_0000);
    waitDone();
    check(rxWord == 32'h0, "R5/R7 zero word back-to-back", rxWord, 32'h0);
    launch(32'hFFFF_FFFF);
    waitDone();
    check(rxWord == 32'hFFFF_FFFF, "R5/R7 all-ones word", rxWord, 32'hFFFF_FFFF);
    frame(32'hAAAA_AAAA, "R5 alternating AAAA");
    frame(32'h5555_5555, "R5 alternating 5555");
    frame(32'h8000_0001, "R4 end bits");
    // R8: start mid-frame with a different word
    launch(32'h1234_5678);
    repeat (40) @(negedge clk);
    launch(32'hCAFE_F00D);
    txWord = 32'h0BAD_0BAD;
    waitDone();
    check(rxWord == 32'h1234_5678, "R8 mid-frame start ignored", rxWord, 32'h1234_5678);
    repeat (3) @(negedge clk);
    check(!busy && serialCsN, "R7 returns idle", {busy, serialCsN}, 2'b01);
    // R5: inverted loopback checks capture of independent slave data
    invertLoop = 1'b1;
    frame(32'h0F0F_3C3C, "R5 inverted loopback");
    invertLoop = 1'b0;
    frame(32'h0000_0001, "R5 lsb only");
    repeat (10) @(negedge clk);
    finishRun();
  end
endmodule